// File: doc/BRIEF.md
# Burst Read-Increment-Write Engine

This block is a bus master that, on a single start pulse, fetches one full-length incrementing burst of 64-bit words from the bottom of memory. It writes each word back, increased by one, into the region that begins just after the words it read. The read-address and write-address requests go out together as soon as the run begins. The engine then streams the read data through a one-word pipeline register into the write-data channel, so that reading and writing overlap. When the final write beat has been accepted, the engine accepts the write response. It then announces completion with a one-cycle pulse that carries the two-bit response code.

The engine keeps a single word of storage, so it runs at one beat per clock when both data channels are ready. A stall on either data channel holds the pipeline and no word is dropped or repeated. A start pulse that arrives while a run is in progress has no effect. Each run covers exactly one burst.

Top module: `burst_inc_engine`

## Requirements
- R1: While reset is held and after it is released, arValid, awValid, wValid, rReady, bReady, busy and done are all 0 until a start pulse is seen.
- R2: In the cycle after a start pulse in the idle state, arValid and awValid are both 1. The read request carries address 0, the write request carries address 2048 (256 words of 8 bytes), and both carry length code 255, size code 3 (8 bytes) and burst code 1 (incrementing). rReady stays 0 until the read request has been accepted.
- R3: The write data words equal the read data words plus one, modulo 2^64, in the order in which they were read. A read word of all ones is written as zero.
- R4: Every write beat carries an all-ones byte strobe (0xFF).
- R5: Each run produces exactly 256 write beats, and wLast is 1 on the 256th beat and on no other beat.
- R6: bReady is 1 only after the write beat with wLast has been accepted.
- R7: One cycle after the write-response handshake, done is 1 for exactly one cycle and doneResp equals the response code that was accepted. busy is 0 from that cycle on.
- R8: When every ready and valid from the slave is held at 1, the 256 write beats are accepted in 256 consecutive cycles.
- R9: Under arbitrary stalls on the read-data and write-data channels, no word is lost, repeated or reordered, and wData and wLast stay stable while wValid is 1 and wReady is 0.
- R10: A start pulse while busy is 1 has no effect: each run issues exactly one read request and one write request.
- R11: Once arValid or awValid is raised, it stays at 1 until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| doneResp | output | 2 | Write response code, valid with done |
| arValid | output | 1 | Read request valid |
| arReady | input | 1 | Read request accepted |
| arAddr | output | 32 | Read burst byte address |
| arLen | output | 8 | Read burst length minus one |
| arSize | output | 3 | Read beat size code |
| arBurst | output | 2 | Read burst type |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data accepted |
| rData | input | 64 | Read data word |
| rResp | input | 2 | Read response (not used) |
| rLast | input | 1 | Last read beat (not used) |
| awValid | output | 1 | Write request valid |
| awReady | input | 1 | Write request accepted |
| awAddr | output | 32 | Write burst byte address |
| awLen | output | 8 | Write burst length minus one |
| awSize | output | 3 | Write beat size code |
| awBurst | output | 2 | Write burst type |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data accepted |
| wData | output | 64 | Write data word |
| wStrb | output | 8 | Write byte strobes |
| wLast | output | 1 | Last write beat |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response accepted |
| bResp | input | 2 | Write response code |

## Verification
The bound checker checks on every cycle that requests and write beats are held until they are accepted. It also checks that each accepted read word reappears incremented on the write channel in the next cycle, that wLast falls on the final beat count, that no read data or response is taken before its prerequisite, that done follows a response handshake, and that a request rises only from an idle start. The bench scenarios show the properties that span a whole run. These are the exact request fields, the end-to-end ordering and wrap of every word under random stalls, the single-cycle-per-beat rate with no backpressure, the response code carried to doneResp, and the fact that start pulses during a run produce no second request.

// File: rtl/eng_pkg.sv
package eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // new run: empty pipeline, zero count
    logic takeBeat;  // read beat accepted this cycle
    logic sendBeat;  // write beat accepted this cycle
  } dpCtrl_t;

  localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/burst_inc_datapath.sv
module burst_inc_datapath
  import eng_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BEATS  = 256,
  localparam int CNT_W = $clog2(BEATS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] rData,
  output logic [DATA_W-1:0] wData,
  output logic              wValid,
  output logic              wLast,
  output logic              readsDone
);

  logic [CNT_W-1:0]  rdCnt;
  logic [DATA_W-1:0] wDataQ;
  logic              wValidQ;
  logic              wLastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCnt   <= '0;
      wDataQ  <= '0;
      wValidQ <= 1'b0;
      wLastQ  <= 1'b0;
    end else if (dpCtrl.clear) begin
      rdCnt   <= '0;
      wValidQ <= 1'b0;
      wLastQ  <= 1'b0;
    end else if (dpCtrl.takeBeat) begin
      // a new word may replace the one leaving in the same cycle
      wDataQ  <= rData + {{(DATA_W-1){1'b0}}, 1'b1};
      wValidQ <= 1'b1;
      wLastQ  <= (rdCnt == CNT_W'(BEATS - 1));
      rdCnt   <= rdCnt + 1'b1;
    end else if (dpCtrl.sendBeat) begin
      wValidQ <= 1'b0;
    end
  end

  assign wData     = wDataQ;
  assign wValid    = wValidQ;
  assign wLast     = wLastQ;
  assign readsDone = (rdCnt == CNT_W'(BEATS));

endmodule

// File: rtl/burst_inc_ctrl.sv
module burst_inc_ctrl
  import eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       arReady,
  input  logic       awReady,
  input  logic       rValid,
  input  logic       wReady,
  input  logic       bValid,
  input  logic [1:0] bResp,
  input  logic       wValid,
  input  logic       wLast,
  input  logic       readsDone,
  output logic       arValid,
  output logic       awValid,
  output logic       rReady,
  output logic       bReady,
  output logic       busy,
  output logic       done,
  output logic [1:0] doneResp,
  output dpCtrl_t    dpCtrl
);

  engState_t state, stateNext;
  logic      arPendQ, awPendQ;
  logic      doneQ;
  logic [1:0] respQ;
  logic      arFree, awFree;

  assign arFree = !arPendQ || arReady;
  assign awFree = !awPendQ || awReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_ADDR;
      ST_ADDR: if (arFree && awFree) stateNext = ST_DATA;
      ST_DATA: if (wValid && wReady && wLast) stateNext = ST_RESP;
      ST_RESP: if (bValid) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      arPendQ <= 1'b0;
      awPendQ <= 1'b0;
      doneQ   <= 1'b0;
      respQ   <= 2'b00;
    end else begin
      state <= stateNext;
      doneQ <= 1'b0;
      if (state == ST_IDLE && start) begin
        arPendQ <= 1'b1;
        awPendQ <= 1'b1;
      end else begin
        if (arReady) arPendQ <= 1'b0;
        if (awReady) awPendQ <= 1'b0;
      end
      if (state == ST_RESP && bValid) begin
        doneQ <= 1'b1;
        respQ <= bResp;
      end
    end
  end

  assign arValid  = arPendQ;
  assign awValid  = awPendQ;
  assign rReady   = (state == ST_DATA) && !readsDone && (!wValid || wReady);
  assign bReady   = (state == ST_RESP);
  assign busy     = (state != ST_IDLE);
  assign done     = doneQ;
  assign doneResp = respQ;

  assign dpCtrl.clear    = (state == ST_IDLE) && start;
  assign dpCtrl.takeBeat = rValid && rReady;
  assign dpCtrl.sendBeat = (state == ST_DATA) && wValid && wReady;

endmodule

// File: rtl/burst_inc_engine.sv
module burst_inc_engine
  import eng_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              DATA_W   = 64,
  parameter int              BEATS    = 256,
  parameter logic [ADDR_W-1:0] SRC_ADDR = '0,
  localparam int             STRB_W   = DATA_W / 8,
  localparam logic [ADDR_W-1:0] DST_ADDR = ADDR_W'(SRC_ADDR + BEATS * STRB_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [1:0]        doneResp,
  output logic              arValid,
  input  logic              arReady,
  output logic [ADDR_W-1:0] arAddr,
  output logic [7:0]        arLen,
  output logic [2:0]        arSize,
  output logic [1:0]        arBurst,
  input  logic              rValid,
  output logic              rReady,
  input  logic [DATA_W-1:0] rData,
  input  logic [1:0]        rResp,
  input  logic              rLast,
  output logic              awValid,
  input  logic              awReady,
  output logic [ADDR_W-1:0] awAddr,
  output logic [7:0]        awLen,
  output logic [2:0]        awSize,
  output logic [1:0]        awBurst,
  output logic              wValid,
  input  logic              wReady,
  output logic [DATA_W-1:0] wData,
  output logic [STRB_W-1:0] wStrb,
  output logic              wLast,
  input  logic              bValid,
  output logic              bReady,
  input  logic [1:0]        bResp
);

  localparam logic [7:0] LEN_CODE  = 8'(BEATS - 1);
  localparam logic [2:0] SIZE_CODE = 3'($clog2(STRB_W));

  dpCtrl_t dpCtrl;
  logic    readsDone;
  logic    unusedR;

  // the burst length is fixed, so the read-side end marker and status are not needed
  assign unusedR = ^{rResp, rLast};

  burst_inc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .arReady  (arReady),
    .awReady  (awReady),
    .rValid   (rValid),
    .wReady   (wReady),
    .bValid   (bValid),
    .bResp    (bResp),
    .wValid   (wValid),
    .wLast    (wLast),
    .readsDone(readsDone),
    .arValid  (arValid),
    .awValid  (awValid),
    .rReady   (rReady),
    .bReady   (bReady),
    .busy     (busy),
    .done     (done),
    .doneResp (doneResp),
    .dpCtrl   (dpCtrl)
  );

  burst_inc_datapath #(
    .DATA_W(DATA_W),
    .BEATS (BEATS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtrl   (dpCtrl),
    .rData    (rData),
    .wData    (wData),
    .wValid   (wValid),
    .wLast    (wLast),
    .readsDone(readsDone)
  );

  assign arAddr  = SRC_ADDR;
  assign awAddr  = DST_ADDR;
  assign arLen   = LEN_CODE;
  assign awLen   = LEN_CODE;
  assign arSize  = SIZE_CODE;
  assign awSize  = SIZE_CODE;
  assign arBurst = BURST_INCR;
  assign awBurst = BURST_INCR;
  assign wStrb   = {STRB_W{1'b1}} | {{(STRB_W-1){1'b0}}, unusedR};

endmodule

// File: rtl/burst_inc_checker.sv
module burst_inc_checker #(
  parameter int DATA_W = 64,
  parameter int BEATS  = 256,
  localparam int CNT_W = $clog2(BEATS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              arValid,
  input logic              arReady,
  input logic              awValid,
  input logic              awReady,
  input logic              rValid,
  input logic              rReady,
  input logic [DATA_W-1:0] rData,
  input logic              wValid,
  input logic              wReady,
  input logic [DATA_W-1:0] wData,
  input logic              wLast,
  input logic              bValid,
  input logic              bReady
);

  logic [CNT_W-1:0] wBeats;
  logic             lastSeen;
  logic             arSeen;
  logic             bHs;

  assign bHs = bValid && bReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wBeats   <= '0;
      lastSeen <= 1'b0;
      arSeen   <= 1'b0;
    end else if (bHs) begin
      wBeats   <= '0;
      lastSeen <= 1'b0;
      arSeen   <= 1'b0;
    end else begin
      if (wValid && wReady) wBeats <= wBeats + 1'b1;
      if (wValid && wReady && wLast) lastSeen <= 1'b1;
      if (arValid && arReady) arSeen <= 1'b1;
    end
  end

  p_ar_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    arValid && !arReady |=> arValid);
  p_aw_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    awValid && !awReady |=> awValid);
  p_w_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !wReady |=> wValid && $stable(wData) && $stable(wLast));
  p_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    rValid && rReady |=> wValid && (wData == $past(rData) + 1'b1));
  p_last_pos_r5: assert property (@(posedge clk) disable iff (!rstN)
    wValid && wLast |-> wBeats == CNT_W'(BEATS - 1));
  p_resp_after_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    bReady |-> lastSeen);
  p_data_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    rReady |-> arSeen);
  p_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(bHs) && !busy);
  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arValid) |-> $past(start) && !$past(busy));

endmodule

bind burst_inc_engine burst_inc_checker #(
  .DATA_W(DATA_W),
  .BEATS (BEATS)
) u_check (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .arValid(arValid),
  .arReady(arReady),
  .awValid(awValid),
  .awReady(awReady),
  .rValid (rValid),
  .rReady (rReady),
  .rData  (rData),
  .wValid (wValid),
  .wReady (wReady),
  .wData  (wData),
  .wLast  (wLast),
  .bValid (bValid),
  .bReady (bReady)
);

// File: tb/sim_burst_inc_engine.sv
`timescale 1ns/1ps
module sim_burst_inc_engine;

  localparam int NB = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done;
  logic [1:0] doneResp;
  logic arValid, arReady;
  logic [31:0] arAddr;
  logic [7:0] arLen;
  logic [2:0] arSize;
  logic [1:0] arBurst;
  logic rValid, rReady;
  logic [63:0] rData;
  logic [1:0] rResp;
  logic rLast;
  logic awValid, awReady;
  logic [31:0] awAddr;
  logic [7:0] awLen;
  logic [2:0] awSize;
  logic [1:0] awBurst;
  logic wValid, wReady;
  logic [63:0] wData;
  logic [7:0] wStrb;
  logic wLast;
  logic bValid, bReady;
  logic [1:0] bResp;

  always #5 clk = ~clk;

  burst_inc_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .doneResp(doneResp),
    .arValid(arValid), .arReady(arReady), .arAddr(arAddr), .arLen(arLen),
    .arSize(arSize), .arBurst(arBurst),
    .rValid(rValid), .rReady(rReady), .rData(rData), .rResp(rResp), .rLast(rLast),
    .awValid(awValid), .awReady(awReady), .awAddr(awAddr), .awLen(awLen),
    .awSize(awSize), .awBurst(awBurst),
    .wValid(wValid), .wReady(wReady), .wData(wData), .wStrb(wStrb), .wLast(wLast),
    .bValid(bValid), .bReady(bReady), .bResp(bResp)
  );

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [63:0] pat(input int run, input int i);
    if (i == 5) return '1;
    return {16'hC0DE, 16'(run), 32'(i) * 32'h9E37_79B9};
  endfunction

  // scoreboard state
  logic [64:0] expQ[$];
  int  runId = 0;
  bit  stallMode = 0;
  logic [1:0] respCode = 2'b00;
  int  arCount = 0, awCount = 0, wCount = 0, doneCount = 0;
  int  rBeat = 0;
  bit  rActive = 0, lastSeen = 0, bDone = 0;
  int  firstWCyc = 0, lastWCyc = 0, bHsCyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  // snapshot of the signals that will be sampled at the next rising edge
  logic sArV, sArR, sAwV, sAwR, sRV, sRR, sWV, sWR, sWL, sBV, sBR, sDone;
  logic [63:0] sRD, sWD;
  logic [7:0] sStrb;
  logic [1:0] sDResp;
  logic [31:0] sArA, sAwA;
  logic [7:0] sArL, sAwL;
  logic [2:0] sArS, sAwS;
  logic [1:0] sArB, sAwB;
  int sCyc;

  task automatic monitorW();
    logic [64:0] e;
    if (wCount == 0) firstWCyc = sCyc;
    if (expQ.size() == 0) begin
      chk(1'b0, "R9 write beat with no pending read word", sWD, 64'd0);
    end else begin
      e = expQ.pop_front();
      chk(sWD == e[63:0], "R3 write word", sWD, e[63:0]);
      chk(sWL == e[64], "R5 wLast position", 64'(sWL), 64'(e[64]));
    end
    chk(sStrb == 8'hFF, "R4 strobe", 64'(sStrb), 64'hFF);
    wCount++;
    if (sWL) begin
      lastSeen = 1;
      lastWCyc = sCyc;
    end
  endtask

  initial begin
    arReady = 0; awReady = 0; rValid = 0; rData = '0; rResp = 2'b00; rLast = 0;
    wReady = 0; bValid = 0; bResp = 2'b00;
    sArV = 0; sArR = 0; sAwV = 0; sAwR = 0; sRV = 0; sRR = 0; sWV = 0; sWR = 0; sWL = 0;
    sBV = 0; sBR = 0; sDone = 0; sRD = '0; sWD = '0; sStrb = '0; sDResp = '0;
    sArA = '0; sAwA = '0; sArL = '0; sAwL = '0; sArS = '0; sAwS = '0; sArB = '0; sAwB = '0;
    sCyc = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (sArV && sArR) begin
          arCount++;
          chk(sArA == 32'd0, "R2 read address", 64'(sArA), 64'd0);
          chk(sArL == 8'd255 && sArS == 3'd3 && sArB == 2'd1, "R2 read fields",
              {40'd0, sArL, 5'd0, sArS, 6'd0, sArB}, {40'd0, 8'd255, 5'd0, 3'd3, 6'd0, 2'd1});
          rBeat = 0;
          rActive = 1;
        end
        if (sAwV && sAwR) begin
          awCount++;
          chk(sAwA == 32'd2048, "R2 write address", 64'(sAwA), 64'd2048);
          chk(sAwL == 8'd255 && sAwS == 3'd3 && sAwB == 2'd1, "R2 write fields",
              {40'd0, sAwL, 5'd0, sAwS, 6'd0, sAwB}, {40'd0, 8'd255, 5'd0, 3'd3, 6'd0, 2'd1});
        end
        if (sRR && arCount == 0) chk(1'b0, "R2 rReady before read request", 64'd1, 64'd0);
        if (sRV && sRR) begin
          expQ.push_back({(rBeat == NB - 1), sRD + 64'd1});
          rBeat++;
          if (rBeat == NB) rActive = 0;
        end
        if (sWV && sWR) monitorW();
        if (sBR) chk(lastSeen, "R6 bReady before last beat", 64'd1, 64'd0);
        if (sBV && sBR) begin
          bDone = 1;
          bHsCyc = sCyc;
        end
        if (sDone) begin
          chk(sDResp == respCode, "R7 doneResp", 64'(sDResp), 64'(respCode));
          chk(sCyc == bHsCyc + 1, "R7 done timing", 64'(sCyc), 64'(bHsCyc + 1));
          doneCount++;
        end
      end
      // drive slave inputs for the next edge
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      arReady = stallMode ? lfsr[0] : 1'b1;
      awReady = stallMode ? lfsr[3] : 1'b1;
      if (!(rValid && !(sRV && sRR))) begin
        rValid = rActive && (stallMode ? (lfsr[5] | lfsr[7]) : 1'b1);
        rData = pat(runId, rBeat);
        rLast = (rBeat == NB - 1);
      end
      wReady = stallMode ? (lfsr[9] | lfsr[11]) : 1'b1;
      if (bValid && sBV && sBR) bValid = 0;
      else if (lastSeen && !bDone) begin
        bValid = 1;
        bResp = respCode;
      end
      #1;
      sCyc = cyc;
      sArV = arValid; sArR = arReady; sArA = arAddr; sArL = arLen; sArS = arSize; sArB = arBurst;
      sAwV = awValid; sAwR = awReady; sAwA = awAddr; sAwL = awLen; sAwS = awSize; sAwB = awBurst;
      sRV = rValid; sRR = rReady; sRD = rData;
      sWV = wValid; sWR = wReady; sWD = wData; sWL = wLast; sStrb = wStrb;
      sBV = bValid; sBR = bReady; sDone = done; sDResp = doneResp;
    end
  end

  task automatic runOnce(input int id, input bit stall, input logic [1:0] code, input bit poke);
    int wd;
    runId = id; stallMode = stall; respCode = code;
    arCount = 0; awCount = 0; wCount = 0; doneCount = 0;
    rActive = 0; lastSeen = 0; bDone = 0; expQ.delete();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    #2;
    chk(arValid && awValid, "R2 both requests raised after start", {62'd0, arValid, awValid}, 64'd3);
    wd = 0;
    while (doneCount == 0 && wd < 20000) begin
      @(negedge clk);
      wd++;
      start = poke && (wd % 37 == 0) && (wCount < 200);
    end
    start = 0;
    chk(wd < 20000, "watchdog", 64'(wd), 64'd20000);
    @(negedge clk);
    #2;
    chk(done == 0, "R7 done lasts one cycle", 64'(done), 64'd0);
    chk(busy == 0, "R7 busy low after done", 64'(busy), 64'd0);
    chk(arCount == 1 && awCount == 1, "R10 one request pair per run",
        64'(arCount * 16 + awCount), 64'd17);
    chk(wCount == NB, "R5 write beat count", 64'(wCount), 64'(NB));
    chk(expQ.size() == 0, "R9 words left unwritten", 64'(expQ.size()), 64'd0);
    repeat (5) @(negedge clk);
    #2;
    chk(!arValid && !awValid, "R10 no request after run", {62'd0, arValid, awValid}, 64'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    chk(!arValid && !awValid && !wValid && !rReady && !bReady && !busy && !done,
        "R1 outputs in reset",
        {57'd0, arValid, awValid, wValid, rReady, bReady, busy, done}, 64'd0);
    rstN = 1;
    repeat (3) @(negedge clk);
    #2;
    chk(!arValid && !awValid && !busy && !done, "R1 idle after reset",
        {60'd0, arValid, awValid, busy, done}, 64'd0);

    runOnce(1, 1'b0, 2'b00, 1'b0);
    chk(lastWCyc - firstWCyc == NB - 1, "R8 back-to-back beats",
        64'(lastWCyc - firstWCyc), 64'(NB - 1));
    runOnce(2, 1'b1, 2'b10, 1'b0);
    runOnce(3, 1'b1, 2'b11, 1'b1);
    runOnce(4, 1'b0, 2'b01, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1500000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule